// File: doc/BRIEF.md
# Complementary Speech PWM with Driver-Strength Select

This block turns a 7-bit unsigned speech sample into a pulse-width-modulated waveform. The waveform appears on a pair of complementary pins. Volume is set separately: a register turns on a chosen set of parallel output drivers of weighted strength. The duty of the waveform is never scaled for volume. A single frame counter runs on the fast clock and sets the timing. The counter only runs while the pulse generator is enabled and the part is not in slow-clock-only mode.

Software uses the block in a fixed order:
1. Set the master bit in the voice-control register.
2. Write the command register. This write sets the generator enable and the three driver-select bits.
3. Stream samples into the sample register. The sample register is shared with a converter path, so it accepts writes at any time.

Two events wipe the command settings: clearing the master bit, and entering sleep or idle mode. After either event the whole sequence must be repeated.

Top module: `speech_pwm`

## Requirements
- R1: After a synchronous active-low reset, `pwm_p`, `pwm_n` and `drv_mask` are all low, and the master bit, the generator enable and the driver selection are cleared.
- R2: While output is active, each frame lasts 128 fast-clock cycles, and `pwm_p` is high for exactly the first N of them, where N is the 7-bit sample (N = 0 gives no high cycle, N = 127 gives 127). The first frame starts in the cycle the output becomes active.
- R3: While output is active, `pwm_n` is the inverse of `pwm_p` in every cycle.
- R4: When the master bit or the generator enable (`cmd_wdata[3]`) is low, `pwm_p`, `pwm_n` and `drv_mask` are all held low.
- R5: A sample written in the middle of a frame does not change that frame; it takes effect from the next frame boundary.
- R6: Command bits `cmd_wdata[2:0]` map to `drv_mask[2:0]`. Bits 2 and 1 each select a double-strength driver and bit 0 selects a single-strength driver. The total strengths for codes 0 to 7 are 0, 1, 2, 3, 2, 3, 4 and 5.
- R7: Writing the master bit to 0 clears the generator enable and the driver selection. Writing the master bit back to 1 does not restore them.
- R8: A command write made while the master bit is 0 is ignored. The same write made after the master bit is set takes effect.
- R9: A cycle with `sleep_req` or `idle_req` high clears the master bit, the enable and the drivers, so all voice output stops. It stays off until software repeats the enable sequence.
- R10: While `slow_only` is high, both pins and `drv_mask` are low and the frame counter is held. When `slow_only` drops, a fresh frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; also the PWM counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_only | input | 1 | High while the part runs from the slow clock only |
| sleep_req | input | 1 | Sleep-mode entry; clears voice output |
| idle_req | input | 1 | Idle-mode entry; clears voice output |
| voice_we | input | 1 | Write strobe for the voice-control master bit |
| voice_pwm | input | 1 | New value of the master bit |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 4 | Bit 3 generator enable, bits 2..0 driver select |
| data_we | input | 1 | Write strobe for the shared sample register |
| data_wdata | input | 7 | Unsigned sample value |
| pwm_p | output | 1 | PWM output |
| pwm_n | output | 1 | Complementary PWM output |
| drv_mask | output | 3 | Active drivers: bits 2,1 double, bit 0 single |

## Verification
The assertions assume that mode entry (`sleep_req`, `idle_req`) and `slow_only` are plain levels sampled on the fast clock. They also assume that at most one write strobe per register is seen in a cycle; the design resolves overlaps by a fixed priority, but the checks rely only on the wipe events.

The stimulus drives each strobe for one whole cycle, away from the clock edge. It raises the master bit only through `voice_we`. Every mode request is held for at least one full cycle, so each wipe and each held window that the assertions observe is complete.

// File: rtl/speech_pwm_pkg.sv
// Shared widths and helpers for the speech PWM block.
// Assumes: sample width sets the frame length (2**width cycles).
package speech_pwm_pkg;
    localparam int SAMPLE_W_DEF = 7;
    localparam int DRV_N_DEF    = 3;

    // Last count of a frame for a given sample width.
    function automatic int frame_last(input int w);
        return (1 << w) - 1;
    endfunction
endpackage

// File: rtl/speech_pwm_ctrl.sv
// Control register file: master bit, command (enable + drivers), sample.
// Assumes: mode requests and the master-clear write both wipe the command
// settings; commands are accepted only while the master bit is set.
module speech_pwm_ctrl #(
    parameter int SAMPLE_W = 7,
    parameter int DRV_N    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic                idle_req,
    input  logic                voice_we,
    input  logic                voice_pwm,
    input  logic                cmd_we,
    input  logic [DRV_N:0]      cmd_wdata,
    input  logic                data_we,
    input  logic [SAMPLE_W-1:0] data_wdata,
    output logic                master_q,
    output logic                pwme_q,
    output logic [DRV_N-1:0]    drv_q,
    output logic [SAMPLE_W-1:0] sample_q
);
    logic mode_off;
    logic wipe;

    // Decode the events that clear the voice settings.
    always_comb begin
        mode_off = sleep_req | idle_req;
        wipe     = mode_off | (voice_we & ~voice_pwm);
    end

    // Master bit: mode entry clears it, otherwise a voice write sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)          master_q <= 1'b0;
        else if (mode_off)   master_q <= 1'b0;
        else if (voice_we)   master_q <= voice_pwm;
    end

    // Command register: wiped with the master bit, written only when armed.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            pwme_q <= 1'b0;
            drv_q  <= '0;
        end else if (cmd_we && master_q) begin
            pwme_q <= cmd_wdata[DRV_N];
            drv_q  <= cmd_wdata[DRV_N-1:0];
        end
    end

    // Shared sample register: always writable.
    always_ff @(posedge clk) begin
        if (!rst_n)       sample_q <= '0;
        else if (data_we) sample_q <= data_wdata;
    end
endmodule

// File: rtl/speech_pwm_frame.sv
// Frame counter and duty comparator.
// Assumes: run is low whenever the counting clock is gated off; the counter
// then holds at zero and the duty register tracks the sample so that a new
// run begins a fresh frame with the latest value.
module speech_pwm_frame #(
    parameter int SAMPLE_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [SAMPLE_W-1:0] sample_q,
    output logic [SAMPLE_W-1:0] cnt_q,
    output logic [SAMPLE_W-1:0] duty_q,
    output logic                raw_hi
);
    localparam logic [SAMPLE_W-1:0] LAST =
        SAMPLE_W'(speech_pwm_pkg::frame_last(SAMPLE_W));

    // Position within the frame; wraps at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    // Duty value in use; reloaded only at a frame boundary while running.
    always_ff @(posedge clk) begin
        if (!rst_n)              duty_q <= '0;
        else if (!run)           duty_q <= sample_q;
        else if (cnt_q == LAST)  duty_q <= sample_q;
    end

    // High phase occupies the first duty_q counts.
    always_comb raw_hi = (cnt_q < duty_q);
endmodule

// File: rtl/speech_pwm_drive.sv
// Output stage: complementary pin pair and per-driver enables.
// Assumes: run already includes master, enable and clock-mode gating.
module speech_pwm_drive #(
    parameter int DRV_N = 3
) (
    input  logic             run,
    input  logic             raw_hi,
    input  logic [DRV_N-1:0] drv_q,
    output logic             pwm_p,
    output logic             pwm_n,
    output logic [DRV_N-1:0] drv_mask
);
    // Pin pair: complementary while running, both low otherwise.
    always_comb begin
        pwm_p = run & raw_hi;
        pwm_n = run & ~raw_hi;
    end

    // One enable per parallel driver.
    for (genvar i = 0; i < DRV_N; i++) begin : g_drv
        always_comb drv_mask[i] = run & drv_q[i];
    end
endmodule

// File: rtl/speech_pwm.sv
// Complementary speech PWM top: registers, frame generator, output stage.
// Assumes: clk is the fast clock; slow_only marks slow-clock-only operation
// in which the counting clock is unavailable.
module speech_pwm #(
    parameter int SAMPLE_W = speech_pwm_pkg::SAMPLE_W_DEF,
    parameter int DRV_N    = speech_pwm_pkg::DRV_N_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slow_only,
    input  logic                sleep_req,
    input  logic                idle_req,
    input  logic                voice_we,
    input  logic                voice_pwm,
    input  logic                cmd_we,
    input  logic [DRV_N:0]      cmd_wdata,
    input  logic                data_we,
    input  logic [SAMPLE_W-1:0] data_wdata,
    output logic                pwm_p,
    output logic                pwm_n,
    output logic [DRV_N-1:0]    drv_mask
);
    logic                master_q;
    logic                pwme_q;
    logic [DRV_N-1:0]    drv_q;
    logic [SAMPLE_W-1:0] sample_q;
    logic [SAMPLE_W-1:0] cnt_q;
    logic [SAMPLE_W-1:0] duty_q;
    logic                raw_hi;
    logic                run;

    // Counting clock gate: armed, enabled and fast clock available.
    always_comb run = master_q & pwme_q & ~slow_only;

    speech_pwm_ctrl #(.SAMPLE_W(SAMPLE_W), .DRV_N(DRV_N)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .sleep_req(sleep_req), .idle_req(idle_req),
        .voice_we(voice_we), .voice_pwm(voice_pwm),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .data_we(data_we), .data_wdata(data_wdata),
        .master_q(master_q), .pwme_q(pwme_q),
        .drv_q(drv_q), .sample_q(sample_q)
    );

    speech_pwm_frame #(.SAMPLE_W(SAMPLE_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .run(run), .sample_q(sample_q),
        .cnt_q(cnt_q), .duty_q(duty_q), .raw_hi(raw_hi)
    );

    speech_pwm_drive #(.DRV_N(DRV_N)) u_drive (
        .run(run), .raw_hi(raw_hi), .drv_q(drv_q),
        .pwm_p(pwm_p), .pwm_n(pwm_n), .drv_mask(drv_mask)
    );
endmodule

// File: rtl/speech_pwm_chk.sv
// Property checker for speech_pwm, attached with bind.
// Assumes: mode requests and slow_only are levels on the fast clock.
module speech_pwm_chk #(
    parameter int SAMPLE_W = 7,
    parameter int DRV_N    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                slow_only,
    input logic                sleep_req,
    input logic                idle_req,
    input logic                voice_we,
    input logic                voice_pwm,
    input logic                cmd_we,
    input logic                pwm_p,
    input logic                pwm_n,
    input logic [DRV_N-1:0]    drv_mask,
    input logic                master_q,
    input logic                pwme_q,
    input logic [DRV_N-1:0]    drv_q,
    input logic                run,
    input logic [SAMPLE_W-1:0] cnt_q,
    input logic [SAMPLE_W-1:0] duty_q
);
    localparam logic [SAMPLE_W-1:0] LAST = '1;

    p_frame_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (!run || cnt_q == SAMPLE_W'($past(cnt_q) + 1'b1)));

    p_pins_opposite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_mask != '0) |-> (pwm_p != pwm_n));

    p_off_when_disarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(master_q && pwme_q) |-> (!pwm_p && !pwm_n && drv_mask == '0));

    p_duty_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q != LAST) |=> (!run || $stable(duty_q)));

    p_master_clear_wipes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (voice_we && !voice_pwm) |=> (!pwme_q && drv_q == '0));

    p_cmd_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !master_q) |=> (!pwme_q && drv_q == '0));

    p_mode_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req || idle_req) |=> (!master_q && !pwme_q && drv_q == '0));

    p_slow_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        slow_only |-> (!pwm_p && !pwm_n && drv_mask == '0));
endmodule

bind speech_pwm speech_pwm_chk #(.SAMPLE_W(SAMPLE_W), .DRV_N(DRV_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .slow_only(slow_only),
    .sleep_req(sleep_req), .idle_req(idle_req),
    .voice_we(voice_we), .voice_pwm(voice_pwm), .cmd_we(cmd_we),
    .pwm_p(pwm_p), .pwm_n(pwm_n), .drv_mask(drv_mask),
    .master_q(master_q), .pwme_q(pwme_q), .drv_q(drv_q),
    .run(run), .cnt_q(cnt_q), .duty_q(duty_q)
);

// File: tb/speech_pwm_test.sv
`timescale 1ns/1ps
module speech_pwm_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_only = 1'b0, sleep_req = 1'b0, idle_req = 1'b0;
    logic       voice_we = 1'b0, voice_pwm = 1'b0;
    logic       cmd_we = 1'b0;
    logic [3:0] cmd_wdata = '0;
    logic       data_we = 1'b0;
    logic [6:0] data_wdata = '0;
    logic       pwm_p, pwm_n;
    logic [2:0] drv_mask;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    speech_pwm uut (
        .clk(clk), .rst_n(rst_n), .slow_only(slow_only),
        .sleep_req(sleep_req), .idle_req(idle_req),
        .voice_we(voice_we), .voice_pwm(voice_pwm),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .data_we(data_we), .data_wdata(data_wdata),
        .pwm_p(pwm_p), .pwm_n(pwm_n), .drv_mask(drv_mask)
    );

    // {driver code, sample}
    localparam logic [9:0] VEC [0:7] = '{
        {3'd0, 7'd0},  {3'd1, 7'd1},   {3'd2, 7'd64}, {3'd3, 7'd127},
        {3'd4, 7'd5},  {3'd5, 7'd100}, {3'd6, 7'd33}, {3'd7, 7'd126}};
    localparam int STRENGTH [0:7] = '{0, 1, 2, 3, 2, 3, 4, 5};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic put_sample(input int s);
        data_we = 1'b1; data_wdata = 7'(s); tick; data_we = 1'b0;
    endtask

    task automatic set_master(input bit v);
        voice_we = 1'b1; voice_pwm = v; tick; voice_we = 1'b0;
    endtask

    task automatic put_cmd(input bit en, input int code);
        cmd_we = 1'b1; cmd_wdata = {en, 3'(code)}; tick; cmd_we = 1'b0;
    endtask

    function automatic int strength(input logic [2:0] m);
        return 2 * int'(m[2]) + 2 * int'(m[1]) + int'(m[0]);
    endfunction

    function automatic bit quiet();
        return !pwm_p && !pwm_n && drv_mask == 3'd0;
    endfunction

    // Walk one frame, counting highs, shape and complement mismatches.
    task automatic one_frame(input int n, output int highs, output int bad_shape,
                             output int bad_comp);
        highs = 0; bad_shape = 0; bad_comp = 0;
        for (int k = 0; k < 128; k++) begin
            if (pwm_p) highs++;
            if (pwm_p != (k < n)) bad_shape++;
            if (pwm_n == pwm_p) bad_comp++;
            tick;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int h, bs, bc, code, s;
        repeat (3) tick;
        check(quiet(), "R1 outputs after reset", int'(pwm_p) + int'(pwm_n) + int'(drv_mask), 0);
        rst_n = 1'b1;
        tick;
        check(quiet(), "R1 outputs idle after release", int'(drv_mask), 0);

        // Vector table: drivers, duty shape, complement, disable.
        for (int i = 0; i < 8; i++) begin
            code = int'(VEC[i][9:7]);
            s    = int'(VEC[i][6:0]);
            put_sample(s);
            set_master(1'b1);
            put_cmd(1'b1, code);
            check(drv_mask == 3'(code), "R6 mask bits", int'(drv_mask), code);
            check(strength(drv_mask) == STRENGTH[code], "R6 driver strength",
                  strength(drv_mask), STRENGTH[code]);
            one_frame(s, h, bs, bc);
            check(h == s && bs == 0, "R2 high cycles in frame", h, s);
            check(bc == 0, "R3 complement mismatches", bc, 0);
            set_master(1'b0);
            check(quiet(), "R4 off after master clear", int'(pwm_p) + int'(pwm_n), 0);
        end

        // R5: mid-frame sample write waits for the boundary.
        put_sample(10);
        set_master(1'b1);
        put_cmd(1'b1, 3);
        h = 0;
        for (int k = 0; k < 128; k++) begin
            if (pwm_p) h++;
            if (k == 20) begin
                data_we = 1'b1; data_wdata = 7'd100;
                tick;
                data_we = 1'b0;
            end else begin
                tick;
            end
        end
        check(h == 10, "R5 frame with mid-frame write", h, 10);
        one_frame(100, h, bs, bc);
        check(h == 100 && bs == 0, "R5 next frame uses new sample", h, 100);

        // R4: master set but generator enable low.
        put_cmd(1'b0, 7);
        tick;
        check(quiet(), "R4 enable low keeps outputs off", int'(drv_mask), 0);

        // R7: master clear wipes, re-arm does not restore.
        put_cmd(1'b1, 7);
        check(drv_mask == 3'd7, "R7 armed mask", int'(drv_mask), 7);
        set_master(1'b0);
        set_master(1'b1);
        tick;
        check(quiet(), "R7 settings not restored", int'(drv_mask), 0);

        // R8: command before master is ignored, after master accepted.
        set_master(1'b0);
        put_cmd(1'b1, 5);
        set_master(1'b1);
        check(quiet(), "R8 early command ignored", int'(drv_mask), 0);
        put_cmd(1'b1, 5);
        check(drv_mask == 3'd5, "R8 ordered command accepted", int'(drv_mask), 5);

        // R9: sleep entry stops output and stays off.
        sleep_req = 1'b1; tick; sleep_req = 1'b0;
        check(quiet(), "R9 sleep stops output", int'(drv_mask), 0);
        put_cmd(1'b1, 5);
        tick;
        check(quiet(), "R9 stays off after sleep", int'(drv_mask), 0);
        set_master(1'b1);
        put_cmd(1'b1, 6);
        check(drv_mask == 3'd6, "R9 re-enabled", int'(drv_mask), 6);
        idle_req = 1'b1; tick; idle_req = 1'b0;
        check(quiet(), "R9 idle stops output", int'(drv_mask), 0);

        // R10: slow-clock-only mode mutes, then a fresh frame starts.
        put_sample(64);
        set_master(1'b1);
        put_cmd(1'b1, 2);
        repeat (37) tick;
        slow_only = 1'b1;
        #1;
        check(quiet(), "R10 quiet in slow-only", int'(drv_mask), 0);
        repeat (5) tick;
        check(quiet(), "R10 still quiet", int'(pwm_p) + int'(pwm_n), 0);
        slow_only = 1'b0;
        #1;
        check(drv_mask == 3'd2, "R10 drivers back", int'(drv_mask), 2);
        one_frame(64, h, bs, bc);
        check(h == 64 && bs == 0, "R10 fresh frame after slow-only", h, 64);

        // R1: reset mid-run clears everything.
        rst_n = 1'b0;
        tick;
        rst_n = 1'b1;
        tick;
        check(quiet(), "R1 reset clears running output", int'(drv_mask), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule